// File: doc/BRIEF.md
# SDRAM Auto Refresh Scheduler

This block keeps a two-bank (by default) SDRAM's contents alive by asking for an auto refresh at a steady rate. An interval timer counts clock cycles. Each time the count expires, one refresh becomes pending. While any refresh is pending, the scheduler raises a request to the command path. When the command path grants the slot, the scheduler puts a command on its command output for that cycle. If a bank still has a row open, that command is a precharge-all. The scheduler then waits out the row precharge time before it offers the auto refresh. The auto refresh goes out only when every bank reports idle and the clock enable was high on the previous cycle. After it goes out, a busy flag holds other traffic off for the refresh cycle time.

The interval defaults to the retention period times the clock rate, divided by the number of rows. Each refresh command covers one row, and the device advances its own row pointer. When the command path is occupied, refreshes can be postponed. The pending count accumulates up to a parameterised ceiling and then saturates. Each issued auto refresh retires one pending refresh.

Top module: `refresh_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `ref_req` is 0, `sched_busy` is 0 and `ref_cmd` is 0 (no operation).
- R2: The interval timer starts at zero on reset. One refresh becomes pending on every REFI_CYCLES-th rising edge after reset is released, so `ref_req` first goes high right after edge number REFI_CYCLES and is low before it.
- R3: `ref_cmd` uses the encoding 0 = no operation, 1 = precharge all banks, 2 = auto refresh. When `ref_req` and `cmd_grant` are both high and any bit of `bank_idle` is 0, the command in that cycle is 1.
- R4: After a precharge-all, `sched_busy` is high for exactly T_RP cycles. During that time `ref_req` stays high and `ref_cmd` stays 0 whatever `cmd_grant` does. After that, a granted request with all banks idle issues the auto refresh.
- R5: An auto refresh (2) is issued only in a cycle where all `bank_idle` bits are 1 and `cke_was_high` is 1. If all banks are idle but `cke_was_high` is 0, `ref_cmd` stays 0 and `ref_req` stays high.
- R6: After an auto refresh, `sched_busy` is high for exactly T_RFC cycles. `ref_req` is low during those cycles.
- R7: A non-zero `ref_cmd` appears only when `cmd_grant` and `ref_req` are both high in that cycle. With no grant, a pending refresh leaves `ref_cmd` at 0.
- R8: Pending refreshes accumulate to at most MAX_PEND, and further interval expiries are dropped. Each auto refresh retires one, and `ref_req` falls once none remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_idle | input | NUM_BANKS | One bit per bank, 1 when that bank has no open row |
| cke_was_high | input | 1 | Clock enable was high in the previous cycle |
| cmd_grant | input | 1 | Command path hands this cycle's command slot to the scheduler |
| ref_req | output | 1 | Scheduler wants the command slot |
| ref_cmd | output | 2 | Command for this cycle: 0 none, 1 precharge all, 2 auto refresh |
| sched_busy | output | 1 | Precharge or refresh wait in progress; other commands must hold off |

## Verification
The checker module watches the properties that hold on every cycle. These are the safety rules: an auto refresh needs all banks idle and the clock enable high, no command goes out without both grant and request, the scheduler is quiet while busy, the request drops after a refresh, and the pending count never passes its ceiling. The directed scenarios cover the behaviour that depends on timing. They measure the exact first request edge and the exact lengths of the precharge and refresh waits. They also show a request being held while the clock enable is low, and that exactly MAX_PEND refreshes are drained after a long period without grant.

// File: rtl/refresh_sched_pkg.sv
`timescale 1ns/1ps
package refresh_sched_pkg;
   typedef enum logic [1:0] {
      RCMD_NOP    = 2'd0,
      RCMD_PREALL = 2'd1,
      RCMD_AREF   = 2'd2
   } rcmd_e;

   typedef enum logic [1:0] {
      RS_RUN  = 2'd0,
      RS_TRP  = 2'd1,
      RS_TRFC = 2'd2
   } rstate_e;
endpackage

// File: rtl/refresh_interval_timer.sv
`timescale 1ns/1ps
module refresh_interval_timer #(
   parameter int PERIOD = 781
) (
   input  logic clk,
   input  logic rst_n,
   output logic expire
);
   localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   assign expire = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (expire) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/refresh_pend_ctr.sv
`timescale 1ns/1ps
module refresh_pend_ctr #(
   parameter int MAX_PEND = 8,
   localparam int PW = $clog2(MAX_PEND + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic          nonzero,
   output logic [PW-1:0] count
);
   generate
      if (MAX_PEND == 1) begin : g_flag
         logic flag_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   flag_q <= 1'b0;
            else if (inc) flag_q <= 1'b1;
            else if (dec) flag_q <= 1'b0;
         end
         assign count   = flag_q;
         assign nonzero = flag_q;
      end else begin : g_count
         localparam logic [PW-1:0] CEIL = PW'(MAX_PEND);
         logic [PW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else if (inc && !dec && cnt_q != CEIL) cnt_q <= cnt_q + 1'b1;
            else if (dec && !inc && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
         end
         assign count   = cnt_q;
         assign nonzero = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/refresh_wait_timer.sv
`timescale 1ns/1ps
module refresh_wait_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/refresh_sched.sv
`timescale 1ns/1ps
module refresh_sched #(
   parameter int NUM_BANKS    = 2,
   parameter int RETENTION_US = 32000,
   parameter int CLK_MHZ      = 50,
   parameter int ROWS         = 2048,
   parameter int REFI_CYCLES  = RETENTION_US * CLK_MHZ / ROWS,
   parameter int T_RP         = 3,
   parameter int T_RFC        = 7,
   parameter int MAX_PEND     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_idle,
   input  logic                 cke_was_high,
   input  logic                 cmd_grant,
   output logic                 ref_req,
   output logic [1:0]           ref_cmd,
   output logic                 sched_busy
);
   import refresh_sched_pkg::*;

   localparam int WMAX = (T_RP > T_RFC) ? T_RP : T_RFC;
   localparam int WW   = (WMAX > 1) ? $clog2(WMAX) : 1;
   localparam int PW   = $clog2(MAX_PEND + 1);

   initial begin
      assert (NUM_BANKS >= 1)   else $error("NUM_BANKS must be at least 1");
      assert (REFI_CYCLES >= 2) else $error("REFI_CYCLES must be at least 2");
      assert (T_RP >= 1)        else $error("T_RP must be at least 1");
      assert (T_RFC >= 1)       else $error("T_RFC must be at least 1");
      assert (MAX_PEND >= 1)    else $error("MAX_PEND must be at least 1");
   end

   rstate_e       state_q, state_d;
   rcmd_e         cmd_d;
   logic          interval_hit;
   logic          pend_nz;
   logic [PW-1:0] pend_cnt;
   logic          retire;
   logic          wait_load;
   logic [WW-1:0] wait_val;
   logic          wait_zero;
   logic          all_idle;

   assign all_idle = &bank_idle;

   refresh_interval_timer #(.PERIOD(REFI_CYCLES)) interval_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (interval_hit)
   );

   refresh_pend_ctr #(.MAX_PEND(MAX_PEND)) pend_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (interval_hit),
      .dec     (retire),
      .nonzero (pend_nz),
      .count   (pend_cnt)
   );

   refresh_wait_timer #(.W(WW)) wait_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wait_load),
      .load_val (wait_val),
      .zero     (wait_zero)
   );

   always_comb begin
      state_d   = state_q;
      cmd_d     = RCMD_NOP;
      retire    = 1'b0;
      wait_load = 1'b0;
      wait_val  = '0;
      unique case (state_q)
         RS_RUN: begin
            if (pend_nz && cmd_grant) begin
               if (!all_idle) begin
                  cmd_d     = RCMD_PREALL;
                  wait_load = 1'b1;
                  wait_val  = WW'(T_RP - 1);
                  state_d   = RS_TRP;
               end else if (cke_was_high) begin
                  cmd_d     = RCMD_AREF;
                  retire    = 1'b1;
                  wait_load = 1'b1;
                  wait_val  = WW'(T_RFC - 1);
                  state_d   = RS_TRFC;
               end
            end
         end
         RS_TRP:  if (wait_zero) state_d = RS_RUN;
         RS_TRFC: if (wait_zero) state_d = RS_RUN;
         default: state_d = RS_RUN;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= RS_RUN;
      else        state_q <= state_d;
   end

   assign ref_cmd    = cmd_d;
   assign sched_busy = (state_q == RS_TRP) || (state_q == RS_TRFC);
   assign ref_req    = (state_q == RS_TRP) || ((state_q == RS_RUN) && pend_nz);
endmodule

// File: rtl/refresh_sched_chk.sv
`timescale 1ns/1ps
module refresh_sched_chk #(
   parameter int NUM_BANKS = 2,
   parameter int MAX_PEND  = 8,
   parameter int PW        = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_BANKS-1:0] bank_idle,
   input logic                 cke_was_high,
   input logic                 cmd_grant,
   input logic                 ref_req,
   input logic [1:0]           ref_cmd,
   input logic                 sched_busy,
   input logic [PW-1:0]        pend_cnt
);
   import refresh_sched_pkg::*;

   // R5
   aref_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cmd == RCMD_AREF) |-> ((&bank_idle) && cke_was_high));

   // R7
   cmd_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cmd != RCMD_NOP) |-> (cmd_grant && ref_req));

   // R6
   aref_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cmd == RCMD_AREF) |=> (sched_busy && !ref_req));

   // R4
   preall_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_cmd == RCMD_PREALL) |=> (sched_busy && ref_req));

   // R4
   quiet_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sched_busy |-> (ref_cmd == RCMD_NOP));

   // R3
   cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_cmd != 2'd3);

   // R8
   pend_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_cnt <= PW'(MAX_PEND));
endmodule

bind refresh_sched refresh_sched_chk #(
   .NUM_BANKS (NUM_BANKS),
   .MAX_PEND  (MAX_PEND),
   .PW        (PW)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .bank_idle    (bank_idle),
   .cke_was_high (cke_was_high),
   .cmd_grant    (cmd_grant),
   .ref_req      (ref_req),
   .ref_cmd      (ref_cmd),
   .sched_busy   (sched_busy),
   .pend_cnt     (pend_cnt)
);

// File: tb/refresh_sched_tb_top.sv
`timescale 1ns/1ps
module refresh_sched_tb_top;
   localparam int REFI  = 20;
   localparam int TRP   = 3;
   localparam int TRFC  = 4;
   localparam int MAXP  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bank_idle = 2'b11;
   logic       cke_was_high = 1'b1;
   logic       cmd_grant = 1'b0;
   logic       ref_req;
   logic [1:0] ref_cmd;
   logic       sched_busy;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   refresh_sched #(
      .NUM_BANKS   (2),
      .REFI_CYCLES (REFI),
      .T_RP        (TRP),
      .T_RFC       (TRFC),
      .MAX_PEND    (MAXP)
   ) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .bank_idle    (bank_idle),
      .cke_was_high (cke_was_high),
      .cmd_grant    (cmd_grant),
      .ref_req      (ref_req),
      .ref_cmd      (ref_cmd),
      .sched_busy   (sched_busy)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic wait_req();
      for (int i = 0; i < 4 * REFI && !ref_req; i++) @(negedge clk);
   endtask

   task automatic wait_boundary();
      do @(negedge clk); while (cyc % REFI != 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check("R1 req in reset", ref_req, 0);
      check("R1 busy in reset", sched_busy, 0);
      check("R1 cmd in reset", ref_cmd, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 req after reset", ref_req, 0);
      check("R1 busy after reset", sched_busy, 0);
   endtask

   task automatic t_interval();
      while (cyc < REFI - 1) @(negedge clk);
      check("R2 req before interval", ref_req, 0);
      @(negedge clk);
      check("R2 req at interval", ref_req, 1);
      check("R7 no cmd without grant", ref_cmd, 0);
   endtask

   task automatic t_plain_refresh();
      cmd_grant = 1'b1;
      #1 check("R3 auto refresh code", ref_cmd, 2);
      @(negedge clk);
      cmd_grant = 1'b0;
      for (int i = 0; i < TRFC; i++) begin
         check("R6 busy during tRFC", sched_busy, 1);
         check("R6 req low during tRFC", ref_req, 0);
         @(negedge clk);
      end
      check("R6 busy ends after tRFC", sched_busy, 0);
      check("R8 req falls when drained", ref_req, 0);
   endtask

   task automatic t_precharge_first();
      wait_req();
      bank_idle = 2'b01;
      cmd_grant = 1'b1;
      #1 check("R3 precharge-all code", ref_cmd, 1);
      @(negedge clk);
      bank_idle = 2'b11;
      #1;
      for (int i = 0; i < TRP; i++) begin
         check("R4 busy during tRP", sched_busy, 1);
         check("R4 req held during tRP", ref_req, 1);
         check("R4 no cmd during tRP", ref_cmd, 0);
         @(negedge clk);
         #1;
      end
      check("R4 busy ends after tRP", sched_busy, 0);
      check("R4 refresh after tRP", ref_cmd, 2);
      @(negedge clk);
      cmd_grant = 1'b0;
      repeat (TRFC) @(negedge clk);
      check("R6 idle after refresh", sched_busy, 0);
   endtask

   task automatic t_cke_gate();
      wait_req();
      cke_was_high = 1'b0;
      cmd_grant = 1'b1;
      #1 check("R5 no refresh with cke low", ref_cmd, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         check("R5 req held with cke low", ref_req, 1);
         check("R5 cmd held with cke low", ref_cmd, 0);
      end
      cke_was_high = 1'b1;
      #1 check("R5 refresh once cke high", ref_cmd, 2);
      @(negedge clk);
      cmd_grant = 1'b0;
      repeat (TRFC) @(negedge clk);
   endtask

   task automatic t_saturate();
      int n_aref = 0;
      cmd_grant = 1'b1;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         #1;
         if (!ref_req && !sched_busy) break;
      end
      cmd_grant = 1'b0;
      repeat (4) wait_boundary();
      check("R7 pending but no grant gives no cmd", ref_cmd, 0);
      check("R8 req with pending work", ref_req, 1);
      cmd_grant = 1'b1;
      for (int i = 0; i < 16; i++) begin
         #1;
         if (ref_cmd == 2) n_aref++;
         @(negedge clk);
      end
      check("R8 refreshes drained equal ceiling", n_aref, MAXP);
      check("R8 req low after drain", ref_req, 0);
      cmd_grant = 1'b0;
   endtask

   initial begin
      t_reset();
      t_interval();
      t_plain_refresh();
      t_precharge_first();
      t_cke_gate();
      t_saturate();
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule